// File: doc/BRIEF.md
# Four-Instruction 8-bit Processor Core

This core is a deliberately minimal processor. It has eight 8-bit registers and four operations:
- a register/memory exchange,
- a bitwise NAND,
- an equality compare that sets a single flag,
- an add that happens only while that flag is set.

There is no separate branch instruction. Register 0 is the program counter, so a conditional add into register 0 moves execution forward by the value of another register. Adding 0xFF moves it back by one, which gives a self-loop.

The core talks to one synchronous byte-wide memory over a 16-bit address port. Reads return data in the cycle after the request. The exchange uses a single read-before-write transaction: the core writes the old register value and receives the old memory byte in the same request. The upper address byte of data exchanges comes from a data bank register inside the core. Instruction fetches always use bank 0. Execution is strictly sequential: one instruction is fetched, decoded and finished before the next fetch.

Top module: `qop_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the core requests a fetch read at address 0x0000 with no write. The program counter, equality flag and data bank are all 0 out of reset.
- R2: Register 1 always reads as 0, and any write aimed at it is discarded. Registers 2..7 come out of reset holding 1, 2, 4, 8, 16 and 32 respectively, and can be overwritten afterwards.
- R3: An instruction byte is decoded as follows:
  - bits [7:6] select the operation: 00 exchange, 01 NAND, 10 compare, 11 conditional add;
  - bits [5:3] name the destination/first register rx;
  - bits [2:0] name the second register ry.
- R4: An exchange whose address is not 0xFF issues one memory request in the cycle after its fetch. That request has the write enable high, the address {bank, value of ry} and the write data equal to rx. In the following cycle rx takes the byte that request read back. An exchange spans 3 cycles from fetch to next fetch; every other instruction spans 2.
- R5: NAND writes ~(rx & ry) into rx.
- R6: Compare sets the flag to 1 when rx equals ry and to 0 otherwise. No other instruction changes the flag. The flag is visible on `eq_flag`.
- R7: Conditional add writes (rx + ry) mod 256 into rx only while the flag is 1. Otherwise the instruction has no effect apart from advancing the program counter.
- R8: Reading register 0 as an operand yields the address of the following instruction. A write to register 0, by a conditional add or by an exchange, replaces the normal increment. So a taken add of register k into register 0 skips k instructions.
- R9: Every instruction fetch reads from bank 0 at the program counter, whatever the current data bank is.
- R10: An exchange whose address register holds 0xFF swaps rx with the data bank register and makes no memory request. The bank then supplies the upper address byte of later exchanges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | output | 1 | Memory request strobe |
| mem_we | output | 1 | Write enable of the request (read-before-write) |
| mem_addr | output | 16 | Request address: bank byte over offset byte |
| mem_wdata | output | 8 | Byte written by an exchange |
| mem_rdata | input | 8 | Byte read by the previous cycle's request |
| eq_flag | output | 1 | Current equality flag |

## Verification
NAND, compare and conditional add are each swept over a 16-by-16 grid of operand pairs. The grid includes 0x00 and 0xFF and sums that wrap, and its diagonal supplies equal operands. The conditional add is run in three settings: after a matching or mismatching compare, after a forced compare, and with the reset flag. This separates flag gating from the arithmetic itself.

Branch programs cover a taken skip of one, a taken skip of two and a not-taken skip. They show that register 0 is read as the next address and that the write replaces the increment. Separate programs dump all reset constants, load the program counter from memory, and move the data bank away and back. These show where each exchange lands and what it returns, and that fetches stay in bank 0.

// File: rtl/qop_pkg.sv
package qop_pkg;

  localparam int DATA_W   = 8;
  localparam int RIDX_W   = 3;
  localparam int NUM_REGS = 1 << RIDX_W;
  localparam int ADDR_W   = 2 * DATA_W;

  typedef enum logic [1:0] {
    OP_XCHG  = 2'b00,
    OP_NAND  = 2'b01,
    OP_CMP   = 2'b10,
    OP_ADDEQ = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'b00,
    ST_EXEC  = 2'b01,
    ST_WBACK = 2'b10
  } seq_e;

  typedef struct packed {
    op_e               op;
    logic [RIDX_W-1:0] rx;
    logic [RIDX_W-1:0] ry;
  } instr_t;

  function automatic instr_t f_decode(input logic [DATA_W-1:0] b);
    instr_t r;
    r.op = op_e'(b[DATA_W-1 -: 2]);
    r.rx = b[2*RIDX_W-1 -: RIDX_W];
    r.ry = b[RIDX_W-1:0];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] f_nand(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    return ~(a & b);
  endfunction

  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    logic [DATA_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DATA_W-1:0];
  endfunction

  function automatic logic f_same(input logic [DATA_W-1:0] a,
                                  input logic [DATA_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

endpackage

// File: rtl/qop_regfile.sv
module qop_regfile
  import qop_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int IW    = RIDX_W,
  localparam int NREG = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_adv,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic [DW-1:0] pc_q
);

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0]            view [NREG];
  logic [NREG-1:2][DW-1:0]  gpr_flat;
  logic                     pc_wr;

  assign pc_wr = wr_en && (wr_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (pc_wr)  pc_q <= wr_data;
    else if (pc_adv) pc_q <= pc_q + ONE;
  end

  // Register 0 is seen by operands as the address of the next instruction.
  assign view[0] = pc_q + ONE;
  assign view[1] = '0;

  for (genvar k = 2; k < NREG; k++) begin : g_gpr
    localparam logic [DW-1:0] INIT = ONE << (k - 2);
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= INIT;
      else if (wr_en && (wr_idx == IW'(k))) q <= wr_data;
    end
    assign view[k]     = q;
    assign gpr_flat[k] = q;
  end

  assign rd_a = view[rd_a_idx];
  assign rd_b = view[rd_b_idx];

  // R2: a write aimed at the zero register leaves every stored register alone
  a_r2_zero_reg_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IW'(1)) |=> $stable(gpr_flat));

  // R8: sequential advance when register 0 is not written
  a_r8_pc_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_adv && !pc_wr) |=> (pc_q == $past(pc_q) + ONE));

  // R8: program counter idle outside of execute
  a_r8_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_adv && !pc_wr) |=> $stable(pc_q));

endmodule

// File: rtl/qop_alu.sv
module qop_alu
  import qop_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          valid,
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          flag_q,
  output logic [DW-1:0] res,
  output logic          res_we,
  output logic          flag_we,
  output logic          flag_d
);

  always_comb begin
    res     = '0;
    res_we  = 1'b0;
    flag_we = 1'b0;
    flag_d  = flag_q;
    if (valid) begin
      unique case (op)
        OP_NAND: begin
          res    = f_nand(a, b);
          res_we = 1'b1;
        end
        OP_CMP: begin
          flag_we = 1'b1;
          flag_d  = f_same(a, b);
        end
        OP_ADDEQ: begin
          res    = f_add(a, b);
          res_we = flag_q;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/qop_seq.sv
module qop_seq
  import qop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go_wback,
  input  instr_t ins_in,
  output seq_e   state_q,
  output instr_t ir_q
);

  seq_e state_d;

  always_comb begin
    unique case (state_q)
      ST_FETCH: state_d = ST_EXEC;
      ST_EXEC:  state_d = go_wback ? ST_WBACK : ST_FETCH;
      default:  state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_EXEC) ir_q <= ins_in;
    end
  end

  // R4: the exchange write-back lasts exactly one cycle
  a_r4_wback_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WBACK) |=> (state_q == ST_FETCH));

  // R4: a fetch is always followed by execute
  a_r4_fetch_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (state_q == ST_EXEC));

endmodule

// File: rtl/qop_core.sv
module qop_core
  import qop_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int IW    = RIDX_W,
  localparam int AW   = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          eq_flag
);

  localparam logic [DW-1:0] BANK_SEL = {DW{1'b1}};

  seq_e    state_q;
  instr_t  ir_q;
  instr_t  cur;
  logic    in_fetch, in_exec, in_wback;
  logic    is_xchg, bank_hit, xchg_mem, xchg_bank;

  logic [DW-1:0] rx_val, ry_val, pc_q;
  logic [DW-1:0] alu_res;
  logic          alu_we, alu_flag_we, alu_flag_d;

  logic          rf_we;
  logic [IW-1:0] rf_idx;
  logic [DW-1:0] rf_data;

  logic          flag_q;
  logic [DW-1:0] bank_q;

  assign in_fetch = (state_q == ST_FETCH);
  assign in_exec  = (state_q == ST_EXEC);
  assign in_wback = (state_q == ST_WBACK);

  // The fetched byte is on mem_rdata during execute; the latched copy serves write-back.
  assign cur = in_exec ? f_decode(mem_rdata) : ir_q;

  assign is_xchg   = (cur.op == OP_XCHG);
  assign bank_hit  = (ry_val == BANK_SEL);
  assign xchg_mem  = in_exec && is_xchg && !bank_hit;
  assign xchg_bank = in_exec && is_xchg && bank_hit;

  qop_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_wback (xchg_mem),
    .ins_in   (cur),
    .state_q  (state_q),
    .ir_q     (ir_q)
  );

  qop_regfile #(.DW(DW), .IW(IW)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_adv   (in_exec),
    .wr_en    (rf_we),
    .wr_idx   (rf_idx),
    .wr_data  (rf_data),
    .rd_a_idx (cur.rx),
    .rd_b_idx (cur.ry),
    .rd_a     (rx_val),
    .rd_b     (ry_val),
    .pc_q     (pc_q)
  );

  qop_alu #(.DW(DW)) u_alu (
    .valid   (in_exec),
    .op      (cur.op),
    .a       (rx_val),
    .b       (ry_val),
    .flag_q  (flag_q),
    .res     (alu_res),
    .res_we  (alu_we),
    .flag_we (alu_flag_we),
    .flag_d  (alu_flag_d)
  );

  // Single register write port: exchange write-back, bank exchange, or ALU result.
  always_comb begin
    rf_idx = cur.rx;
    if (in_wback) begin
      rf_we   = 1'b1;
      rf_data = mem_rdata;
    end else if (xchg_bank) begin
      rf_we   = 1'b1;
      rf_data = bank_q;
    end else begin
      rf_we   = alu_we;
      rf_data = alu_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      bank_q <= '0;
    end else begin
      if (alu_flag_we) flag_q <= alu_flag_d;
      if (xchg_bank)   bank_q <= rx_val;
    end
  end

  assign mem_en    = in_fetch || xchg_mem;
  assign mem_we    = xchg_mem;
  assign mem_addr  = in_fetch ? {{DW{1'b0}}, pc_q} : {bank_q, ry_val};
  assign mem_wdata = xchg_mem ? rx_val : '0;
  assign eq_flag   = flag_q;

  // R4: writes only ever ride on a request
  a_r4_write_has_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  // R4: a memory exchange is followed by an idle port during write-back
  a_r4_xchg_then_wback: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_mem |=> (in_wback && !mem_en));

  // R10: a bank exchange never touches memory
  a_r10_bank_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_bank |-> !mem_en);

  // R6: the flag moves only when a compare executes
  a_r6_flag_only_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_exec && cur.op == OP_CMP) |=> $stable(flag_q));

  // R7: a conditional add with a clear flag writes no register
  a_r7_addeq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && cur.op == OP_ADDEQ && !flag_q) |-> !rf_we);

  // R9: fetch requests never carry a write
  a_r9_fetch_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch |-> (mem_en && !mem_we));

endmodule

// File: tb/tb_qop_core.sv
`timescale 1ns/1ps
module tb_qop_core;

  localparam int SW = 0, NA = 1, CP = 2, AE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_en, mem_we, eq_flag;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  always #4 clk = ~clk;

  qop_core dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .eq_flag   (eq_flag)
  );

  logic [7:0]  mem [0:65535];
  logic [15:0] wr_a [64];
  logic [7:0]  wr_d [64];
  logic        wr_f [64];
  logic [15:0] f_a  [64];
  int          f_c  [64];
  int          n_wr = 0, n_f = 0, cyc = 0;
  logic [15:0] target = 16'h0;
  logic        hit = 1'b0;
  int          ntests = 0, nfail = 0;

  // Behavioural synchronous memory, read-before-write, plus a port log.
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_en) begin
      mem_rdata <= mem[mem_addr];
      if (mem_we) mem[mem_addr] = mem_wdata;
    end
    if (rst_n && mem_en) begin
      if (mem_we) begin
        if (n_wr < 64) begin
          wr_a[n_wr] = mem_addr; wr_d[n_wr] = mem_wdata; wr_f[n_wr] = eq_flag;
          n_wr = n_wr + 1;
        end
        if (mem_addr == target) hit = 1'b1;
      end else if (n_f < 64) begin
        f_a[n_f] = mem_addr; f_c[n_f] = cyc;
        n_f = n_f + 1;
      end
    end
  end

  function automatic logic [7:0] ins(input int op, input int rx, input int ry);
    return 8'((op << 6) | (rx << 3) | ry);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'h00;
      mem[16'h1000 + a] = 8'h00;
    end
    n_wr = 0; n_f = 0; hit = 1'b0;
  endtask

  task automatic run_to(input logic [15:0] t, input string req);
    target = t;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 200 && !hit; k++) @(negedge clk);
    if (!hit) chk(req, "target write never seen", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int a, b, exp, lastw;
    repeat (2) @(negedge clk);
    // R1: port state while held in reset
    chk("R1", "mem_en in reset", int'(mem_en), 1);
    chk("R1", "mem_we in reset", int'(mem_we), 0);
    chk("R1", "mem_addr in reset", int'(mem_addr), 0);
    chk("R1", "eq_flag in reset", int'(eq_flag), 0);

    // R2: dump register constants (and register 1 twice) to address 0
    begin_prog();
    mem[0] = ins(SW, 1, 1);
    for (int r = 2; r < 8; r++) mem[r - 1] = ins(SW, r, 1);
    mem[7] = ins(SW, 1, 1);
    target = 16'hFFFF;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 100 && n_wr < 8; k++) @(negedge clk);
    chk("R1", "first fetch address", int'(f_a[0]), 0);
    chk("R2", "write count", n_wr, 8);
    chk("R2", "register 1 first dump", int'(wr_d[0]), 0);
    for (int r = 2; r < 8; r++) chk("R2", "reset constant", int'(wr_d[r - 1]), 1 << (r - 2));
    chk("R2", "register 1 after load attempt", int'(wr_d[7]), 0);
    chk("R4", "exchange address bank 0", int'(wr_a[3]), 0);

    // R3 R5 R6 R7: operand sweeps
    for (int v = 0; v < 5; v++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          a = i * 17; b = (j * 17) & 8'hFF;
          begin_prog();
          mem[0] = ins(SW, 2, 6);
          mem[1] = ins(SW, 3, 7);
          mem[16'h10] = 8'(a);
          mem[16'h20] = 8'(b);
          case (v)
            0: begin mem[2] = ins(NA, 2, 3); mem[3] = ins(SW, 2, 5); exp = (~(a & b)) & 8'hFF; end
            1: begin mem[2] = ins(CP, 2, 3); mem[3] = ins(SW, 2, 5); exp = a; end
            2: begin mem[2] = ins(CP, 2, 3); mem[3] = ins(AE, 2, 3); mem[4] = ins(SW, 2, 5);
                     exp = (a == b) ? ((a + b) % 256) : a; end
            3: begin mem[2] = ins(CP, 1, 1); mem[3] = ins(AE, 2, 3); mem[4] = ins(SW, 2, 5);
                     exp = (a + b) % 256; end
            default: begin mem[2] = ins(AE, 2, 3); mem[3] = ins(SW, 2, 5); exp = a; end
          endcase
          run_to(16'h0008, "R3");
          lastw = (n_wr > 0) ? int'(wr_d[n_wr - 1]) : -1;
          case (v)
            0: begin
              chk("R5", "nand result", lastw, exp);
              chk("R4", "exchange fetch gap", f_c[1] - f_c[0], 3);
              chk("R4", "non-exchange fetch gap", f_c[3] - f_c[2], 2);
              chk("R2", "load into register 2 via exchange", int'(wr_d[0]), 1);
            end
            1: begin
              chk("R6", "compare leaves operand", lastw, exp);
              chk("R6", "flag after compare", int'(wr_f[n_wr - 1]), int'(a == b));
            end
            2: chk("R7", "addeq after compare", lastw, exp);
            3: chk("R7", "addeq forced", lastw, exp);
            default: begin
              chk("R7", "addeq with reset flag", lastw, exp);
              chk("R6", "flag untouched by others", int'(wr_f[n_wr - 1]), 0);
            end
          endcase
        end
      end
    end

    // R8: relative branches through register 0
    for (int s = 0; s < 3; s++) begin
      begin_prog();
      mem[0] = (s == 2) ? ins(CP, 2, 3) : ins(CP, 1, 1);
      mem[1] = (s == 1) ? ins(AE, 0, 2) : ins(AE, 0, 3);
      mem[2] = ins(SW, 2, 5);
      mem[3] = ins(SW, 3, 5);
      mem[4] = ins(SW, 4, 5);
      run_to(16'h0008, "R8");
      exp = (s == 0) ? 4 : ((s == 1) ? 2 : 1);
      chk("R8", "branch landing", int'(wr_d[0]), exp);
      chk("R8", "third fetch address", int'(f_a[2]), (s == 0) ? 4 : ((s == 1) ? 3 : 2));
    end

    // R8: exchange into register 0 loads the program counter
    begin_prog();
    mem[0] = ins(SW, 0, 6);
    mem[16'h10] = 8'h30;
    mem[16'h30] = ins(SW, 4, 5);
    run_to(16'h0008, "R8");
    chk("R8", "register 0 operand value", int'(wr_d[0]), 1);
    chk("R8", "register 0 exchange address", int'(wr_a[0]), 16'h0010);
    chk("R8", "fetch after pc load", int'(f_a[1]), 16'h0030);
    chk("R8", "instruction at new pc", int'(wr_d[1]), 4);

    // R9 R10: data bank moves, fetches stay in bank 0
    begin_prog();
    mem[0] = ins(NA, 7, 1);
    mem[1] = ins(SW, 6, 7);
    mem[2] = ins(SW, 5, 1);
    mem[3] = ins(SW, 5, 4);
    mem[4] = ins(SW, 6, 7);
    mem[5] = ins(SW, 6, 3);
    mem[16'h1000] = 8'h77;
    run_to(16'h0002, "R10");
    chk("R10", "memory writes seen", n_wr, 3);
    chk("R10", "bank exchange address", int'(wr_a[0]), 16'h1000);
    chk("R10", "bank exchange data", int'(wr_d[0]), 8);
    chk("R10", "read from data bank", int'(wr_d[1]), 8'h77);
    chk("R10", "second banked address", int'(wr_a[1]), 16'h1004);
    chk("R10", "old bank returned", int'(wr_d[2]), 8'h10);
    chk("R10", "bank restored address", int'(wr_a[2]), 16'h0002);
    chk("R10", "bank exchange fetch gap", f_c[2] - f_c[1], 2);
    chk("R9", "fetch in bank 0 under bank 0x10", int'(f_a[3]), 16'h0003);

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule